// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which of two oscillators feeds the system clock: a primary oscillator or an internal RC oscillator. A 2-bit select field asks for a source. The block drives an enable for each oscillator, the select line of the downstream clock multiplexer, and a status flag. The flag reports that the primary oscillator has completed its start-up interval and is now driving the clock.

When the RC source is requested, the block waits for a safe switching point, moves the multiplexer to RC, turns the primary oscillator off and clears the flag. When the primary source is requested again, the system keeps running from RC while the primary oscillator restarts. The block counts a fixed number of primary periods as a start-up interval, and only after that does it move the multiplexer to the primary clock. The multiplexer select changes only in a cycle where the synchronized levels of both oscillators are low. While the primary source drives the clock, the RC oscillator is switched off unless the watchdog or the clock monitor needs it.

All logic runs on a free-running control clock. Both oscillator outputs come in as asynchronous levels and pass through two-flop synchronizers before use.

Top module: `clksrc_switch`

## Requirements
- R1: During and right after reset, the outputs are: primary enable 1, RC enable 1, mux select 0 (RC), flag 0. The primary start-up count begins from zero.
- R2: Select code 2'b11 requests RC. From primary mode, the switch completes at a safe point. From then on the primary enable is 0, the mux select is 0 and the flag is 0.
- R3: Select codes 2'b01 and 2'b10 are ignored. The source requested last by 2'b00 or 2'b11 stays in effect.
- R4: The mux select stays 0 until OST_CYCLES (default 1024) rising edges of the synchronized primary level have been counted since the primary enable was last raised.
- R5: The flag rises in the same cycle that the mux select moves to 1 (primary). It is 1 exactly while the mux select is 1.
- R6: The mux select changes only on a clock edge where the synchronized levels of both oscillators were low.
- R7: While the primary clock is selected and no switch is pending, the RC enable equals watchdog-enable OR monitor-enable, one edge later. In every other state it is 1.
- R8: Requesting RC while the start-up count is still running cancels the pending switch. The primary enable drops at the next edge, and a later request for the primary source counts from zero again.
- R9: A request for RC from primary mode that is withdrawn before the safe switching point leaves the primary clock selected, with the flag still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source request: 00 primary, 11 RC, others ignored |
| wdog_en | input | 1 | Watchdog needs the RC oscillator |
| clkmon_en | input | 1 | Clock monitor needs the RC oscillator |
| pri_osc_lvl | input | 1 | Asynchronous level of the primary oscillator |
| rc_osc_lvl | input | 1 | Asynchronous level of the RC oscillator |
| pri_osc_en | output | 1 | Primary oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| mux_sel_pri | output | 1 | Clock mux select, 1 = primary |
| ost_ready | output | 1 | Start-up complete, primary drives the clock |

## Verification
A change on the select field or on the watchdog and monitor enables shows up on the outputs at the first rising edge that samples it. The oscillator levels take longer to matter: two synchronizer stages, plus one more register for primary edge detection, come before they can move the state. The bench model holds the sampled oscillator levels in a short queue, so each edge uses the values those registers would hold. It advances on the same rising edge as the design and compares all four outputs at the following falling edge. The directed checks sample at fixed points well clear of the start-up window limits, for example 3000 cycles into a start-up interval of about 4100 cycles.

// File: rtl/clksrc_switch_pkg.sv
package clksrc_switch_pkg;

  typedef enum logic [1:0] {
    ST_RC   = 2'd0,
    ST_WARM = 2'd1,
    ST_PRI  = 2'd2,
    ST_TORC = 2'd3
  } sw_state_t;

  localparam logic [1:0] REQ_PRI = 2'b00;
  localparam logic [1:0] REQ_RC  = 2'b11;

endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clksrc_ost_timer.sv
module clksrc_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic lvl_s,
  output logic done
);

  localparam int CW = $clog2(OST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          lvl_prev;
  logic          rise;

  assign rise = lvl_s & ~lvl_prev;
  assign done = (cnt == CW'(OST_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl_s;
  end

  always_ff @(posedge clk) begin
    if (rst || clear)             cnt <= '0;
    else if (run && rise && !done) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/clksrc_fsm.sv
module clksrc_fsm
  import clksrc_switch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       wdog_en,
  input  logic       clkmon_en,
  input  logic       pri_s,
  input  logic       rc_s,
  input  logic       ost_done,
  output logic       tmr_clear,
  output logic       tmr_run,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       mux_sel_pri,
  output logic       ost_ready
);

  sw_state_t state_q, state_n;
  logic      want_pri_q, want_pri;
  logic      both_low;

  assign both_low  = !pri_s && !rc_s;
  assign tmr_clear = (state_q == ST_RC);
  assign tmr_run   = (state_q == ST_WARM);

  always_comb begin
    if (src_sel == REQ_PRI)     want_pri = 1'b1;
    else if (src_sel == REQ_RC) want_pri = 1'b0;
    else                        want_pri = want_pri_q;
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_RC:   if (want_pri) state_n = ST_WARM;
      ST_WARM: begin
        if (!want_pri)                state_n = ST_RC;
        else if (ost_done && both_low) state_n = ST_PRI;
      end
      ST_PRI:  if (!want_pri) state_n = ST_TORC;
      ST_TORC: begin
        if (want_pri)      state_n = ST_PRI;
        else if (both_low) state_n = ST_RC;
      end
      default: state_n = ST_WARM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_WARM;
      want_pri_q  <= 1'b1;
      pri_osc_en  <= 1'b1;
      rc_osc_en   <= 1'b1;
      mux_sel_pri <= 1'b0;
      ost_ready   <= 1'b0;
    end else begin
      state_q     <= state_n;
      want_pri_q  <= want_pri;
      pri_osc_en  <= (state_n != ST_RC);
      rc_osc_en   <= (state_n == ST_PRI) ? (wdog_en | clkmon_en) : 1'b1;
      mux_sel_pri <= (state_n == ST_PRI) || (state_n == ST_TORC);
      ost_ready   <= (state_n == ST_PRI) || (state_n == ST_TORC);
    end
  end

endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch #(
  parameter int OST_CYCLES  = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] src_sel,
  input  logic       wdog_en,
  input  logic       clkmon_en,
  input  logic       pri_osc_lvl,
  input  logic       rc_osc_lvl,
  output logic       pri_osc_en,
  output logic       rc_osc_en,
  output logic       mux_sel_pri,
  output logic       ost_ready
);

  // lvl_sync[0] = primary, lvl_sync[1] = RC
  logic [1:0] lvl_sync;
  logic       ost_done;
  logic       tmr_clear;
  logic       tmr_run;

  clksrc_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (2)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({rc_osc_lvl, pri_osc_lvl}),
    .q   (lvl_sync)
  );

  clksrc_ost_timer #(
    .OST_CYCLES (OST_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .run   (tmr_run),
    .lvl_s (lvl_sync[0]),
    .done  (ost_done)
  );

  clksrc_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .src_sel     (src_sel),
    .wdog_en     (wdog_en),
    .clkmon_en   (clkmon_en),
    .pri_s       (lvl_sync[0]),
    .rc_s        (lvl_sync[1]),
    .ost_done    (ost_done),
    .tmr_clear   (tmr_clear),
    .tmr_run     (tmr_run),
    .pri_osc_en  (pri_osc_en),
    .rc_osc_en   (rc_osc_en),
    .mux_sel_pri (mux_sel_pri),
    .ost_ready   (ost_ready)
  );

endmodule

// File: rtl/clksrc_switch_chk.sv
module clksrc_switch_chk (
  input logic       clk,
  input logic       rst,
  input logic       pri_osc_en,
  input logic       rc_osc_en,
  input logic       mux_sel_pri,
  input logic       ost_ready,
  input logic [1:0] lvl_sync,
  input logic       ost_done
);

  p_pri_off_in_rc_r2: assert property (@(posedge clk) disable iff (rst)
    !pri_osc_en |-> (!mux_sel_pri && !ost_ready && rc_osc_en));

  p_handover_after_ost_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mux_sel_pri) |-> $past(ost_done));

  p_flag_with_select_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ost_ready) |-> (mux_sel_pri && pri_osc_en));

  p_switch_when_low_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mux_sel_pri) |-> $past(lvl_sync == 2'b00));

  p_rc_off_only_pri_r7: assert property (@(posedge clk) disable iff (rst)
    !rc_osc_en |-> (mux_sel_pri && ost_ready && pri_osc_en));

endmodule

bind clksrc_switch clksrc_switch_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pri_osc_en  (pri_osc_en),
  .rc_osc_en   (rc_osc_en),
  .mux_sel_pri (mux_sel_pri),
  .ost_ready   (ost_ready),
  .lvl_sync    (lvl_sync),
  .ost_done    (ost_done)
);

// File: tb/clksrc_switch_tb.sv
`timescale 1ns/1ps
module clksrc_switch_tb;

  localparam int OST = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_sel = 2'b00;
  logic       wdog_en = 1'b0;
  logic       clkmon_en = 1'b0;
  logic       pri_lvl = 1'b0;
  logic       rc_lvl = 1'b0;
  logic       pri_osc_en, rc_osc_en, mux_sel_pri, ost_ready;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  clksrc_switch #(.OST_CYCLES(OST), .SYNC_STAGES(2)) u_dut (
    .clk (clk), .rst (rst), .src_sel (src_sel),
    .wdog_en (wdog_en), .clkmon_en (clkmon_en),
    .pri_osc_lvl (pri_lvl), .rc_osc_lvl (rc_lvl),
    .pri_osc_en (pri_osc_en), .rc_osc_en (rc_osc_en),
    .mux_sel_pri (mux_sel_pri), .ost_ready (ost_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // oscillator levels: primary period 4 cycles, RC period 6 cycles
  int ph = 0;
  always @(negedge clk) begin
    ph++;
    if (ph % 2 == 0) pri_lvl <= ~pri_lvl;
    if (ph % 3 == 0) rc_lvl  <= ~rc_lvl;
  end

  // behavioural reference: 0 RC, 1 warming, 2 primary, 3 leaving primary
  int m_st, m_cnt;
  bit m_tgt, m_pe, m_re, m_ms, m_fl;
  bit ps, pp, rs, want, done;
  bit pq[$];
  bit rq[$];

  always @(posedge clk) begin
    if (rst) begin
      m_st = 1; m_cnt = 0; m_tgt = 1;
      pq = '{0, 0, 0}; rq = '{0, 0, 0};
      m_pe = 1; m_re = 1; m_ms = 0; m_fl = 0;
    end else begin
      ps = pq[1]; pp = pq[2]; rs = rq[1];
      if (src_sel == 2'b00)      want = 1;
      else if (src_sel == 2'b11) want = 0;
      else                       want = m_tgt;
      done = (m_cnt >= OST);
      if (m_st == 0) m_cnt = 0;
      else if (m_st == 1 && ps && !pp && m_cnt < OST) m_cnt++;
      case (m_st)
        0: if (want) m_st = 1;
        1: if (!want) m_st = 0; else if (done && !ps && !rs) m_st = 2;
        2: if (!want) m_st = 3;
        default: if (want) m_st = 2; else if (!ps && !rs) m_st = 0;
      endcase
      m_tgt = want;
      m_pe = (m_st != 0);
      m_re = (m_st == 2) ? (wdog_en | clkmon_en) : 1'b1;
      m_ms = (m_st >= 2);
      m_fl = (m_st >= 2);
      pq.push_front(pri_lvl); void'(pq.pop_back());
      rq.push_front(rc_lvl);  void'(rq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 pri_osc_en vs model", pri_osc_en, m_pe);
      chk("R7 rc_osc_en vs model", rc_osc_en, m_re);
      chk("R6 mux_sel_pri vs model", mux_sel_pri, m_ms);
      chk("R5 ost_ready vs model", ost_ready, m_fl);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_cyc(4);
    chk("R1 reset pri_osc_en", pri_osc_en, 1'b1);
    chk("R1 reset rc_osc_en", rc_osc_en, 1'b1);
    chk("R1 reset mux_sel_pri", mux_sel_pri, 1'b0);
    chk("R1 reset ost_ready", ost_ready, 1'b0);
    rst = 1'b0;
    cmp_on = 1;

    wait_cyc(3000);
    chk("R4 still on RC mid start-up", mux_sel_pri, 1'b0);
    chk("R4 flag clear mid start-up", ost_ready, 1'b0);
    wait_cyc(1300);
    chk("R5 flag set after start-up", ost_ready, 1'b1);
    chk("R4 primary selected after start-up", mux_sel_pri, 1'b1);
    chk("R7 RC off with no user", rc_osc_en, 1'b0);

    wdog_en = 1'b1; wait_cyc(2);
    chk("R7 RC on for watchdog", rc_osc_en, 1'b1);
    wdog_en = 1'b0; clkmon_en = 1'b1; wait_cyc(2);
    chk("R7 RC on for monitor", rc_osc_en, 1'b1);
    clkmon_en = 1'b0; wait_cyc(2);
    chk("R7 RC off again", rc_osc_en, 1'b0);

    src_sel = 2'b01; wait_cyc(100);
    chk("R3 code 01 ignored in primary", mux_sel_pri, 1'b1);
    src_sel = 2'b10; wait_cyc(100);
    chk("R3 code 10 ignored in primary", pri_osc_en, 1'b1);

    src_sel = 2'b11; wait_cyc(1);
    src_sel = 2'b00; wait_cyc(30);
    chk("R9 withdrawn request keeps primary", mux_sel_pri, 1'b1);
    chk("R9 withdrawn request keeps flag", ost_ready, 1'b1);

    src_sel = 2'b11; wait_cyc(30);
    chk("R2 primary disabled in RC", pri_osc_en, 1'b0);
    chk("R2 mux on RC", mux_sel_pri, 1'b0);
    chk("R2 flag cleared", ost_ready, 1'b0);
    chk("R2 RC enabled", rc_osc_en, 1'b1);

    src_sel = 2'b10; wait_cyc(100);
    chk("R3 code 10 ignored in RC", pri_osc_en, 1'b0);
    src_sel = 2'b01; wait_cyc(100);
    chk("R3 code 01 ignored in RC", pri_osc_en, 1'b0);

    src_sel = 2'b00; wait_cyc(2000);
    chk("R8 primary restarting", pri_osc_en, 1'b1);
    src_sel = 2'b11; wait_cyc(1);
    chk("R8 cancel disables primary at once", pri_osc_en, 1'b0);
    wait_cyc(20);
    src_sel = 2'b00; wait_cyc(3500);
    chk("R8 count restarted from zero", ost_ready, 1'b0);
    wait_cyc(1000);
    chk("R8 handover after full restart", ost_ready, 1'b1);
    chk("R4 primary selected after restart", mux_sel_pri, 1'b1);

    wait_cyc(10);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule